// File: doc/BRIEF.md
# SPI EEPROM Page-Write Slave

This block is the write side of a small serial EEPROM, seen from a SPI bus master. Its byte storage is a register array of up to 512 locations. It runs entirely in the system clock domain. Chip select, serial clock and serial input pass through two-flop synchronizers, and the serial clock edges are recovered from the synchronized level. The system clock must therefore run several times faster than the serial clock.

The master first sets the write-enable latch with a one-byte instruction. It then sends a write instruction, a byte address, and between one and sixteen data bytes. The data bytes collect in a page buffer. When chip select rises, the buffered bytes are copied into the array and a busy interval of a configurable number of clock cycles begins. During that interval only status reads are honoured. At the end of the interval the write-enable latch clears itself.

A parallel read port exposes the array contents to the neighbouring read path. This block does not decode a serial read instruction.

Top module: `spi_pgwr_slave`

## Requirements
- R1: A write instruction received while the write-enable latch is clear is discarded. No byte of the array changes and no busy interval starts.
- R2: Instruction byte 0x06 sets the write-enable latch. Instruction byte 0x05 shifts out the status byte {6'b0, WEL, RDY} on SO, MSB first. SO changes after a falling SCK edge and is valid at the next rising edge. Further bytes clocked under the same chip select repeat the status.
- R3: The write instruction byte is 0000_X010, received MSB first. X is address bit 8 when the array holds 512 bytes. The instruction is followed by address bits 7..0, MSB first, and then the data bytes, MSB first.
- R4: The busy interval starts only on a rising chip select after at least one complete data byte has arrived. If chip select rises in the middle of a byte, or before any data byte, the whole write is dropped and the write-enable latch keeps its value.
- R5: Once the busy interval starts, RDY reads 1 for exactly WR_CYCLES clock cycles. During that interval every instruction other than 0x05 is ignored.
- R6: The write-enable latch is 0 when the busy interval ends.
- R7: After each data byte, the low 4 bits of the address advance and the page bits stay fixed. Past offset 15 the address returns to offset 0 of the same page, and the later byte replaces the earlier one.
- R8: Only page locations that received a complete byte are written. Other locations of that page keep their contents.
- R9: so_drive is 0, and SO is high impedance, unless a status byte is being shifted out. In particular SO is not driven during a write instruction or while chip select is high.
- R10: SPI modes 0 and 3 both work, with SI sampled on the rising SCK edge.
- R11: After reset the array holds all zeros, the write-enable latch is 0 and RDY is 0.
- R12: mem_rdata shows the array byte at mem_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out, high impedance when not driven |
| so_drive | output | 1 | High while SO is driven |
| mem_addr | input | ADDR_W | Array read address for the neighbouring read path |
| mem_rdata | output | 8 | Array byte at mem_addr |

## Verification
Two situations are hard to reach from the pins. One is the busy interval overlapping other traffic. The other is a chip select that rises after a whole number of bytes but not a whole transfer. For the first, the stimulus issues a status read and then a complete write instruction while RDY is still 1. It uses a long busy parameter so that this traffic fits inside the interval. For the second, it sends a write whose last byte is cut off after four bits, and a write that ends right after the address. It then shows that RDY never rose, that WEL survived, and that the array did not change. Page wrap is driven with 18 bytes from offset 0, so that two early bytes are overwritten and the rest of the page is left as written.

// File: rtl/spw_pkg.sv
`timescale 1ns/1ps
package spw_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_STAT,
        PH_SKIP
    } spw_phase_e;

    localparam logic [7:0] INS_SET_WEL  = 8'h06;
    localparam logic [7:0] INS_STATUS   = 8'h05;
    localparam logic [7:0] INS_PROGRAM  = 8'h02;
    localparam logic [7:0] INS_HIBIT_MK = 8'h08;
endpackage

// File: rtl/spw_sync.sv
`timescale 1ns/1ps
module spw_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= d;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spw_array.sv
`timescale 1ns/1ps
module spw_array #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [PG_W-1:0]             page,
    input  logic [PAGE_BYTES-1:0][7:0]  lat_data,
    input  logic [PAGE_BYTES-1:0]       lat_vld,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [7:0]                  rd_data
);
    logic [7:0] mem_d [MEM_BYTES];
    logic [7:0] mem_q [MEM_BYTES];

    always_comb begin
        for (int i = 0; i < MEM_BYTES; i++) begin
            mem_d[i] = mem_q[i];
            if (commit && (page == PG_W'(i / PAGE_BYTES)) && lat_vld[i % PAGE_BYTES]) begin
                mem_d[i] = lat_data[i % PAGE_BYTES];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spi_pgwr_slave.sv
`timescale 1ns/1ps
module spi_pgwr_slave
    import spw_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 2000,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_drive,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_rdata
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;
    localparam logic [OFF_W-1:0] OFF_ONE  = 1;

    typedef struct packed {
        spw_phase_e                 phase;
        logic [2:0]                 bitcnt;
        logic [7:0]                 shreg;
        logic                       sck_prev;
        logic                       cs_prev;
        logic                       wel;
        logic                       busy;
        logic [CNT_W-1:0]           bcnt;
        logic                       hibit;
        logic [PG_W-1:0]            page;
        logic [OFF_W-1:0]           off;
        logic                       got;
        logic [PAGE_BYTES-1:0][7:0] lat;
        logic [PAGE_BYTES-1:0]      vld;
        logic [7:0]                 so_sh;
        logic                       so_oe;
        logic                       so_first;
        logic                       commit;
    } st_t;

    st_t        st_d, st_q;
    logic       cs_s, sck_s, si_s;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;
    logic [7:0] nxt_byte, status;
    logic [8:0] full_addr;
    logic       busy_w, wel_w;

    spw_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si}),
        .q     ({cs_s, sck_s, si_s})
    );

    assign busy_w   = st_q.busy;
    assign wel_w    = st_q.wel;
    assign status   = {6'b0, wel_w, busy_w};
    assign sck_rise = sck_s & ~st_q.sck_prev;
    assign sck_fall = ~sck_s & st_q.sck_prev;
    assign cs_fall  = ~cs_s & st_q.cs_prev;
    assign cs_rise  = cs_s & ~st_q.cs_prev;
    assign nxt_byte = {st_q.shreg[6:0], si_s};

    always_comb begin
        st_d          = st_q;
        st_d.commit   = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_s;
        full_addr     = {st_q.hibit, nxt_byte};

        if (st_q.busy) begin
            if (st_q.bcnt == CNT_LAST) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.bcnt = '0;
            end else begin
                st_d.bcnt = st_q.bcnt + CNT_ONE;
            end
        end

        if (cs_fall) begin
            st_d.phase  = PH_OPC;
            st_d.bitcnt = '0;
            st_d.got    = 1'b0;
            st_d.so_oe  = 1'b0;
        end else if (cs_rise) begin
            if (st_q.phase == PH_DATA && st_q.got && st_q.bitcnt == 3'd0) begin
                st_d.busy   = 1'b1;
                st_d.bcnt   = '0;
                st_d.commit = 1'b1;
            end
            st_d.phase = PH_IDLE;
            st_d.so_oe = 1'b0;
        end else if (!cs_s) begin
            if (sck_rise && st_q.phase != PH_IDLE) begin
                st_d.shreg  = nxt_byte;
                st_d.bitcnt = st_q.bitcnt + 3'd1;
                if (st_q.bitcnt == 3'd7) begin
                    unique case (st_q.phase)
                        PH_OPC: begin
                            if (nxt_byte == INS_STATUS) begin
                                st_d.phase    = PH_STAT;
                                st_d.so_sh    = status;
                                st_d.so_oe    = 1'b1;
                                st_d.so_first = 1'b1;
                            end else if (st_q.busy) begin
                                st_d.phase = PH_SKIP;
                            end else if (nxt_byte == INS_SET_WEL) begin
                                st_d.wel   = 1'b1;
                                st_d.phase = PH_SKIP;
                            end else if ((nxt_byte & ~INS_HIBIT_MK) == INS_PROGRAM && st_q.wel) begin
                                st_d.phase = PH_ADDR;
                                st_d.hibit = nxt_byte[3];
                                st_d.vld   = '0;
                            end else begin
                                st_d.phase = PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            st_d.page  = full_addr[ADDR_W-1:OFF_W];
                            st_d.off   = full_addr[OFF_W-1:0];
                            st_d.phase = PH_DATA;
                        end
                        PH_DATA: begin
                            st_d.lat[st_q.off] = nxt_byte;
                            st_d.vld[st_q.off] = 1'b1;
                            st_d.off           = st_q.off + OFF_ONE;
                            st_d.got           = 1'b1;
                        end
                        PH_STAT: begin
                            st_d.so_sh    = status;
                            st_d.so_first = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && st_q.so_oe) begin
                if (st_q.so_first) st_d.so_first = 1'b0;
                else               st_d.so_sh    = {st_q.so_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    spw_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (st_q.commit),
        .page     (st_q.page),
        .lat_data (st_q.lat),
        .lat_vld  (st_q.vld),
        .rd_addr  (mem_addr),
        .rd_data  (mem_rdata)
    );

    assign so_drive = st_q.so_oe;
    assign so       = st_q.so_oe ? st_q.so_sh[7] : 1'bz;
endmodule

// File: rtl/spw_checker.sv
`timescale 1ns/1ps
module spw_checker #(
    parameter int WR_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic busy,
    input logic wel,
    input logic so_oe
);
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= busy ? run_q + 1 : 0;
    end

    AST_WEL_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);                                         // R6
    AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);                                          // R1
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == WR_CYCLES));                         // R5
    AST_WEL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wel));                       // R5
    AST_SO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe); // R9
endmodule

bind spi_pgwr_slave spw_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .busy  (busy_w),
    .wel   (wel_w),
    .so_oe (so_drive)
);

// File: tb/sim_spi_pgwr_slave.sv
`timescale 1ns/1ps
module sim_spi_pgwr_slave;
    localparam int WR = 2000;
    localparam int H  = 160;

    typedef struct {
        string      req;
        bit         is_mem;
        logic [8:0] addr;
        logic [7:0] exp;
        logic [7:0] got;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    wire        so;
    logic       so_drive;
    logic [8:0] mem_addr = '0;
    logic [7:0] mem_rdata;
    bit         mode3 = 1'b0;
    bit         done = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;
    item_t      sbq[$];
    logic [7:0] buf8 [20];

    always #10 clk = ~clk;

    spi_pgwr_slave #(.MEM_BYTES(512), .PAGE_BYTES(16), .WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_drive(so_drive), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // monitor: pops expected items and compares against design results
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                if (it.is_mem) begin
                    mem_addr = it.addr;
                    @(negedge clk);
                    it.got = mem_rdata;
                end
                check(it.req, it.got, it.exp);
            end
        end
    end

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            #H;
            sck = 1'b1;
            rx[i] = so_drive ? so : 1'b0;
            #H;
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic sel();
        sck = mode3 ? 1'b1 : 1'b0;
        cs_n = 1'b0;
        #H;
    endtask

    task automatic desel();
        #H;
        cs_n = 1'b1;
        #(4*H);
    endtask

    task automatic sb_status(input string req, input logic [7:0] exp);
        logic [7:0] r;
        item_t it;
        sel();
        xfer(8'h05, 8, r);
        xfer(8'h00, 8, r);
        desel();
        it.req = req; it.is_mem = 1'b0; it.addr = '0; it.exp = exp; it.got = r;
        sbq.push_back(it);
        drain();
    endtask

    task automatic sb_mem(input string req, input logic [8:0] a, input logic [7:0] exp);
        item_t it;
        it.req = req; it.is_mem = 1'b1; it.addr = a; it.exp = exp; it.got = '0;
        sbq.push_back(it);
        drain();
    endtask

    task automatic wren();
        logic [7:0] r;
        sel();
        xfer(8'h06, 8, r);
        desel();
    endtask

    task automatic wr(input logic [7:0] op, input logic [7:0] a, input int n, input int tail_bits);
        logic [7:0] r;
        sel();
        xfer(op, 8, r);
        xfer(a, 8, r);
        check("R9 so_drive during write", {7'b0, so_drive}, 8'h00);
        for (int k = 0; k < n; k++) xfer(buf8[k], 8, r);
        if (tail_bits > 0) xfer(8'hFF, tail_bits, r);
        desel();
    endtask

    task automatic wait_cycle();
        #(WR * 20 + 4000);
    endtask

    initial begin
        #(3);
        #(100);
        rst_n = 1'b1;
        #(200);

        // R11 reset state
        check("R11 so_drive after reset", {7'b0, so_drive}, 8'h00);
        sb_status("R11 status after reset", 8'h00);
        sb_mem("R11 array cleared", 9'h1FF, 8'h00);

        // R1 write without WEL
        buf8[0] = 8'hAA;
        wr(8'h02, 8'h10, 1, 0);
        sb_status("R1 no busy without WEL", 8'h00);
        sb_mem("R1 byte untouched", 9'h010, 8'h00);

        // R2 set WEL
        wren();
        sb_status("R2 WEL set", 8'h02);

        // R3 three-byte write, R5 busy behaviour
        buf8[0] = 8'h11; buf8[1] = 8'h22; buf8[2] = 8'h33;
        wr(8'h02, 8'h23, 3, 0);
        sb_status("R5 RDY high in cycle", 8'h03);
        buf8[0] = 8'h55;
        wr(8'h02, 8'h40, 1, 0);
        sb_status("R5 still busy", 8'h03);
        wait_cycle();
        sb_status("R6 WEL cleared at end", 8'h00);
        sb_mem("R3 byte0", 9'h023, 8'h11);
        sb_mem("R3 byte1", 9'h024, 8'h22);
        sb_mem("R12 read port byte2", 9'h025, 8'h33);
        sb_mem("R8 below untouched", 9'h022, 8'h00);
        sb_mem("R8 above untouched", 9'h026, 8'h00);
        sb_mem("R5 write during busy ignored", 9'h040, 8'h00);

        // R7 page wrap from offset 14
        wren();
        buf8[0] = 8'hA0; buf8[1] = 8'hA1; buf8[2] = 8'hA2; buf8[3] = 8'hA3;
        wr(8'h02, 8'h5E, 4, 0);
        wait_cycle();
        sb_mem("R7 off14", 9'h05E, 8'hA0);
        sb_mem("R7 off15", 9'h05F, 8'hA1);
        sb_mem("R7 wrap off0", 9'h050, 8'hA2);
        sb_mem("R7 wrap off1", 9'h051, 8'hA3);
        sb_mem("R7 next page untouched", 9'h060, 8'h00);
        sb_mem("R8 off2 untouched", 9'h052, 8'h00);

        // R7 eighteen bytes overwrite
        wren();
        for (int k = 0; k < 18; k++) buf8[k] = 8'(8'h80 + k);
        wr(8'h02, 8'h70, 18, 0);
        wait_cycle();
        sb_mem("R7 overwrite off0", 9'h070, 8'h90);
        sb_mem("R7 overwrite off1", 9'h071, 8'h91);
        sb_mem("R7 off2 kept", 9'h072, 8'h82);
        sb_mem("R7 off15 kept", 9'h07F, 8'h8F);

        // R3 address bit 8 in opcode bit 3
        wren();
        buf8[0] = 8'h5A;
        wr(8'h0A, 8'h05, 1, 0);
        wait_cycle();
        sb_mem("R3 upper half", 9'h105, 8'h5A);
        sb_mem("R3 lower half untouched", 9'h005, 8'h00);

        // R4 partial byte abort
        wren();
        buf8[0] = 8'h77;
        wr(8'h02, 8'h30, 1, 4);
        sb_status("R4 partial: no busy, WEL kept", 8'h02);
        sb_mem("R4 partial: nothing stored", 9'h030, 8'h00);

        // R4 no data byte
        wr(8'h02, 8'h31, 0, 0);
        sb_status("R4 no data: no busy", 8'h02);
        sb_mem("R4 no data: nothing stored", 9'h031, 8'h00);

        // R10 mode 3
        mode3 = 1'b1;
        buf8[0] = 8'hC3;
        wr(8'h02, 8'h90, 1, 0);
        sb_status("R10 mode3 busy status", 8'h03);
        wait_cycle();
        sb_status("R10 mode3 ready status", 8'h00);
        sb_mem("R10 mode3 byte stored", 9'h090, 8'hC3);
        mode3 = 1'b0;
        sck = 1'b0;
        #(H);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(3_000_000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule